// File: doc/BRIEF.md
# Shadow Reload Bank

This block holds the configuration of a set of datapath units. Each unit has two copies of its setting: a pending copy and an active copy. Software writes only the pending copies, through a single-cycle register bus. The active copies drive the datapath. A pending copy moves into its active copy only at a frame boundary, and only after software has committed the batch.

A per-unit freeze array decides which units take part in a transfer. After reset every unit is frozen. Software thaws a unit by clearing its bit, then arms the transfer by writing 1 to the control register. The next frame-end strobe copies every thawed pending value into its active register in a single clock edge, so the datapath never sees half of one configuration and half of another. The arm is then consumed. Writing 0 to the control register stops the engine and drops any arm.

Active copies can be read back at a separate debug address range. Each freeze bit can be read back as part of its word.

Top module: `shadow_reload_bank`

## Requirements
- R1: After reset, every pending and every active value is zero. Both freeze words read 0xFFFFFFFF. The control register reads 0.
- R2: A bus write to address n (0x00 to 0x3F) stores the low 16 data bits as the pending value of unit n. A read of address n returns that value zero-extended to 32 bits. The active copy of unit n is not changed.
- R3: A read of address 0x40+n returns the active value of unit n. A bus write to the range 0x40 to 0x7F changes no pending value and no active value.
- R4: Freeze bit of unit n sits in freeze word n/32, at bit position n mod 32. Freeze word 0 is at address 0x80 and word 1 is at 0x81. Both words can be written and read back.
- R5: A transfer takes place on a clock edge where frame_end is high, the engine is enabled and a commit is armed. On that edge, each unit whose freeze bit is 0 copies its pending value into its active value. The new value is visible from the following cycle.
- R6: A unit whose freeze bit is 1 keeps its active value during a transfer.
- R7: A frame_end strobe when no commit is armed changes no active value.
- R8: A transfer clears the arm. A later frame_end with no new commit changes nothing.
- R9: A second commit write made before the frame_end strobe has no extra effect. Exactly one transfer happens, and the arm is then clear.
- R10: Writing 0 to bit 0 of the control register (0x82) disables the engine and drops any armed commit. No transfer follows.
- R11: Active values change only on the clock edge after a transfer condition. All permitted units change on that same edge.
- R12: A read of the control register (0x82) returns the engine-enabled flag in bit 0 and the armed flag in bit 1. Writing 1 to bit 0 sets both flags.
- R13: Suppose a pending write and a transfer fall on the same edge. The active copy then takes the pending value held before that edge, and the pending copy takes the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously inside the block |
| frame_end | input | 1 | Frame boundary strobe, one cycle wide |
| bus_wr | input | 1 | Write strobe of the register bus |
| bus_addr | input | 8 | Word address of the register bus |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| active_cfg | output | 1024 | Active values of all units. Unit n uses bits n*16 to n*16+15 |

## Verification
The bound checker watches on every cycle that active values move only on the edge after a transfer condition. It also checks that frozen units and strobes without an arm leave the active values alone, that a transfer consumes the arm, that a disabled engine never holds an arm, and that each pending write lands in its unit. Some behaviours show only over a scenario, so the bench covers them:
- the freeze-word bit mapping for units in both words;
- the consumption of a doubled commit;
- writes to the debug range being ignored;
- the result of a pending write that meets the strobe on the same edge;
- the reset state after a reset partway through the run.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int BUS_W  = 32;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_ACT  = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/shadow_bank_decode.sv
module shadow_bank_decode
  import shadow_bank_pkg::*;
#(
  parameter int UNIT_AW = 6,
  parameter int ADDR_W  = UNIT_AW + 2
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [UNIT_AW-1:0] idx
);
  always_comb begin
    region = region_e'(addr[ADDR_W-1 -: 2]);
    idx    = addr[UNIT_AW-1:0];
  end
endmodule

// File: rtl/shadow_bank_commit.sv
module shadow_bank_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic ctrl_bit,
  input  logic frame_end,
  output logic enabled,
  output logic armed,
  output logic xfer
);
  logic en_d, arm_d;

  assign xfer = frame_end & armed & enabled;

  always_comb begin
    en_d  = enabled;
    arm_d = armed;
    if (ctrl_wr) begin
      en_d  = ctrl_bit;
      arm_d = ctrl_bit;
    end else if (xfer) begin
      arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      armed   <= 1'b0;
    end else begin
      enabled <= en_d;
      armed   <= arm_d;
    end
  end
endmodule

// File: rtl/shadow_bank_unit.sv
module shadow_bank_unit #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             load,
  output logic [CFG_W-1:0] pend_q,
  output logic [CFG_W-1:0] act_q
);
  logic [CFG_W-1:0] pend_d, act_d;

  always_comb begin
    pend_d = wr_en ? wdata  : pend_q;
    act_d  = load  ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end
endmodule

// File: rtl/shadow_reload_bank.sv
module shadow_reload_bank
  import shadow_bank_pkg::*;
#(
  parameter int NUM_UNITS = 64,
  parameter int CFG_W     = 16,
  parameter int ADDR_W    = $clog2(NUM_UNITS) + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_end,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  output logic [NUM_UNITS*CFG_W-1:0] active_cfg
);
  localparam int UNIT_AW   = ADDR_W - 2;
  localparam int DIS_WORDS = NUM_UNITS / WORD_W;
  localparam logic [UNIT_AW-1:0] CTRL_IDX = UNIT_AW'(DIS_WORDS);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  region_e            region;
  logic [UNIT_AW-1:0] idx;

  shadow_bank_decode #(.UNIT_AW(UNIT_AW), .ADDR_W(ADDR_W)) dec_i (
    .addr   (bus_addr),
    .region (region),
    .idx    (idx)
  );

  logic pend_wr, ctrl_region_wr, ctrl_wr;
  assign pend_wr        = bus_wr & (region == REG_PEND);
  assign ctrl_region_wr = bus_wr & (region == REG_CTRL);
  assign ctrl_wr        = ctrl_region_wr & (idx == CTRL_IDX);

  logic enabled, armed, xfer;
  shadow_bank_commit commit_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bit  (bus_wdata[0]),
    .frame_end (frame_end),
    .enabled   (enabled),
    .armed     (armed),
    .xfer      (xfer)
  );

  // freeze array, one word register per WORD_W units, reset to all ones
  logic [NUM_UNITS-1:0] dis_bits;
  for (genvar w = 0; w < DIS_WORDS; w++) begin : g_dis
    logic              we;
    logic [WORD_W-1:0] dis_q, dis_d;
    assign we = ctrl_region_wr & (idx == UNIT_AW'(w));
    always_comb dis_d = we ? bus_wdata[WORD_W-1:0] : dis_q;
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) dis_q <= '1;
      else             dis_q <= dis_d;
    end
    assign dis_bits[w*WORD_W +: WORD_W] = dis_q;
  end

  logic [CFG_W-1:0]           wr_cfg;
  logic [CFG_W-1:0]           pend_arr [NUM_UNITS];
  logic [CFG_W-1:0]           act_arr  [NUM_UNITS];
  logic [NUM_UNITS*CFG_W-1:0] pend_flat;
  assign wr_cfg = bus_wdata[CFG_W-1:0];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    shadow_bank_unit #(.CFG_W(CFG_W)) unit_i (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_en  (pend_wr & (idx == UNIT_AW'(u))),
      .wdata  (wr_cfg),
      .load   (xfer & ~dis_bits[u]),
      .pend_q (pend_arr[u]),
      .act_q  (act_arr[u])
    );
    assign active_cfg[u*CFG_W +: CFG_W] = act_arr[u];
    assign pend_flat[u*CFG_W +: CFG_W]  = pend_arr[u];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (region)
      REG_PEND: bus_rdata = BUS_W'(pend_arr[idx]);
      REG_ACT:  bus_rdata = BUS_W'(act_arr[idx]);
      REG_CTRL: begin
        for (int w = 0; w < DIS_WORDS; w++)
          if (idx == UNIT_AW'(w)) bus_rdata = BUS_W'(dis_bits[w*WORD_W +: WORD_W]);
        if (idx == CTRL_IDX) bus_rdata = BUS_W'({armed, enabled});
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/shadow_reload_bank_chk.sv
module shadow_reload_bank_chk #(
  parameter int NUM_UNITS = 64,
  parameter int CFG_W     = 16,
  parameter int ADDR_W    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frame_end,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [CFG_W-1:0]           wr_cfg,
  input logic                       enabled,
  input logic                       armed,
  input logic [NUM_UNITS-1:0]       dis_bits,
  input logic [NUM_UNITS*CFG_W-1:0] active_cfg,
  input logic [NUM_UNITS*CFG_W-1:0] pend_flat
);
  localparam int UNIT_AW = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((2 << UNIT_AW) + NUM_UNITS / 32);

  logic go, ctl_wr;
  assign go     = frame_end & armed & enabled;
  assign ctl_wr = bus_wr & (bus_addr == CTRL_ADDR);

  AST_ACTIVE_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_cfg) |-> $past(go)); // R11
  AST_NO_XFER_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !armed) |=> $stable(active_cfg)); // R7
  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ctl_wr) |=> !armed); // R8
  AST_DISABLED_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !armed); // R10

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    AST_FROZEN_UNIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (go && dis_bits[u]) |=> $stable(active_cfg[u*CFG_W +: CFG_W])); // R6
    AST_PENDING_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(u)) |=> pend_flat[u*CFG_W +: CFG_W] == $past(wr_cfg)); // R2
  end
endmodule

bind shadow_reload_bank shadow_reload_bank_chk #(
  .NUM_UNITS (NUM_UNITS),
  .CFG_W     (CFG_W),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .frame_end  (frame_end),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .wr_cfg     (wr_cfg),
  .enabled    (enabled),
  .armed      (armed),
  .dis_bits   (dis_bits),
  .active_cfg (active_cfg),
  .pend_flat  (pend_flat)
);

// File: tb/shadow_reload_bank_tb_top.sv
`timescale 1ns/1ps
module shadow_reload_bank_tb_top;
  localparam int NU = 64;
  localparam int CW = 16;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_FE = 2'd2;
  localparam int NV = 42;
  // {op[1:0], req[3:0], addr[7:0], data_or_expected[31:0]}
  localparam logic [45:0] VEC [NV] = '{
    {OP_RD, 4'd1,  8'h80, 32'hFFFFFFFF},  // R1
    {OP_RD, 4'd1,  8'h81, 32'hFFFFFFFF},  // R1
    {OP_RD, 4'd12, 8'h82, 32'h0},         // R12
    {OP_WR, 4'd2,  8'h05, 32'h1234},      // R2
    {OP_RD, 4'd2,  8'h05, 32'h1234},      // R2
    {OP_RD, 4'd2,  8'h45, 32'h0},         // R2 active untouched
    {OP_WR, 4'd2,  8'h07, 32'hFFFFFFFF},  // R2
    {OP_RD, 4'd2,  8'h07, 32'h0000FFFF},  // R2 zero-extend
    {OP_WR, 4'd4,  8'h80, 32'hFFFFFFDF},  // R4 thaw unit 5
    {OP_RD, 4'd4,  8'h80, 32'hFFFFFFDF},  // R4
    {OP_FE, 4'd7,  8'h00, 32'h0},         // R7
    {OP_RD, 4'd7,  8'h45, 32'h0},         // R7
    {OP_WR, 4'd5,  8'h82, 32'h1},         // R5 commit
    {OP_RD, 4'd12, 8'h82, 32'h3},         // R12
    {OP_FE, 4'd5,  8'h00, 32'h0},         // R5
    {OP_RD, 4'd5,  8'h45, 32'h1234},      // R5
    {OP_RD, 4'd6,  8'h47, 32'h0},         // R6 unit 7 frozen
    {OP_RD, 4'd8,  8'h82, 32'h1},         // R8
    {OP_WR, 4'd8,  8'h05, 32'h5555},      // R8
    {OP_FE, 4'd8,  8'h00, 32'h0},         // R8
    {OP_RD, 4'd8,  8'h45, 32'h1234},      // R8
    {OP_WR, 4'd4,  8'h25, 32'hABCD},      // R4 unit 37
    {OP_WR, 4'd6,  8'h26, 32'h7777},      // R6 unit 38
    {OP_WR, 4'd4,  8'h81, 32'hFFFFFFDF},  // R4 thaw unit 37
    {OP_WR, 4'd9,  8'h82, 32'h1},         // R9
    {OP_WR, 4'd9,  8'h82, 32'h1},         // R9 repeat
    {OP_FE, 4'd9,  8'h00, 32'h0},         // R9
    {OP_RD, 4'd4,  8'h65, 32'hABCD},      // R4
    {OP_RD, 4'd6,  8'h66, 32'h0},         // R6
    {OP_RD, 4'd5,  8'h45, 32'h5555},      // R5
    {OP_RD, 4'd9,  8'h82, 32'h1},         // R9
    {OP_WR, 4'd9,  8'h25, 32'h1111},      // R9
    {OP_FE, 4'd9,  8'h00, 32'h0},         // R9
    {OP_RD, 4'd9,  8'h65, 32'hABCD},      // R9
    {OP_WR, 4'd3,  8'h45, 32'hDEAD},      // R3 ignored
    {OP_RD, 4'd3,  8'h45, 32'h5555},      // R3
    {OP_WR, 4'd10, 8'h05, 32'h0F0F},      // R10
    {OP_WR, 4'd10, 8'h82, 32'h1},         // R10
    {OP_WR, 4'd10, 8'h82, 32'h0},         // R10
    {OP_RD, 4'd10, 8'h82, 32'h0},         // R10
    {OP_FE, 4'd10, 8'h00, 32'h0},         // R10
    {OP_RD, 4'd10, 8'h45, 32'h5555}       // R10
  };

  logic              clk, rst_n, frame_end, bus_wr;
  logic [7:0]        bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NU*CW-1:0]  active_cfg;
  int errors = 0, checks = 0;
  bit done = 0;

  shadow_reload_bank dut_i (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .active_cfg(active_cfg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic fe();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; frame_end = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();
    check("R1", 32'(active_cfg == '0), 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [7:0]  a;
      logic [31:0] d;
      {op, rq, a, d} = VEC[i];
      case (op)
        OP_WR:   wr(a, d);
        OP_RD:   rd(a, d, $sformatf("R%0d", rq));
        default: fe();
      endcase
    end

    // R11: datapath port carries the transferred values of both words' units
    @(negedge clk);
    check("R11", 32'(active_cfg[5*CW +: CW]), 32'h5555);
    check("R11", 32'(active_cfg[37*CW +: CW]), 32'hABCD);

    // R13: pending write meets the strobe on the same edge
    wr(8'h82, 32'h1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h05; bus_wdata = 32'h2222; frame_end = 1'b1;
    @(negedge clk); bus_wr = 1'b0; frame_end = 1'b0;
    rd(8'h45, 32'h0F0F, "R13");
    rd(8'h05, 32'h2222, "R13");

    // R1: reset in the middle of the run
    do_reset();
    rd(8'h45, 32'h0, "R1");
    rd(8'h05, 32'h0, "R1");
    rd(8'h81, 32'hFFFFFFFF, "R1");
    rd(8'h82, 32'h0, "R1");
    check("R1", 32'(active_cfg == '0), 32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule